// File: doc/BRIEF.md
# Shift and Rotate Unit with Separate Extend Flag

This unit performs the shift and rotate part of an integer execution stage. One operation is accepted per cycle. Each operation names a mode, an operand size (8, 16 or 32 bits), a shift count of 0 to 63 and the current extend flag. One cycle later the unit returns the result and four condition flags: zero, negative, carry and extend.

Extend is kept apart from carry. Logical and arithmetic shifts update both. Plain rotates update only carry. The two rotate-through-extend modes treat extend as one more bit in the rotation ring, so at a given size the ring is one bit wider than the operand. For 8-bit and 16-bit operations the unselected upper bits of the 32-bit operand pass through to the result unchanged.

The result and the flags are registered. They change only in cycles where an operation is presented, and they hold their values between operations.

Top module: `shrot_unit`

## Requirements
- R1: `size_i` selects the operand width: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. Bits of `result_o` above the selected width equal the matching bits of `data_i`. `op_i` encodes the mode: 0 logical left, 1 logical right, 2 arithmetic left, 3 arithmetic right, 4 rotate left, 5 rotate right, 6 rotate left through extend, 7 rotate right through extend.
- R2: Logical and arithmetic left shifts move the operand left by the count and fill with zeros. With a nonzero count, carry and extend both take the last bit shifted out. Counts at or above the width give a zero result.
- R3: Logical right shift fills the vacated upper bits with zero. With a nonzero count, carry and extend take the last bit shifted out.
- R4: Arithmetic right shift fills the vacated upper bits with copies of the operand's sign bit. With a nonzero count, carry and extend take the last bit shifted out. For counts at or above the width this is the sign bit.
- R5: Plain rotates circulate bits within the operand width only. With a nonzero count, carry is the last bit rotated out: the result's least significant bit for a left rotate and its most significant bit for a right rotate. Extend is left unchanged.
- R6: Rotates through extend use a ring of width+1 bits, with extend above the operand's most significant bit. The new extend is the bit left in that position. Carry equals the new extend.
- R7: A count of zero leaves the result and extend unchanged. Carry is cleared, except for rotates through extend, where carry takes the incoming extend.
- R8: Negative equals the result's most significant bit at the selected width. Zero is set when all result bits at that width are zero.
- R9: The result and flags update one cycle after `valid_i` is high. `valid_o` marks that cycle. With `valid_i` low the outputs hold. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Mode code (R1) |
| size_i | input | 2 | Operand width code (R1) |
| count_i | input | 6 | Shift or rotate count, 0 to 63 |
| data_i | input | 32 | Operand |
| xflag_i | input | 1 | Current extend flag |
| result_o | output | 32 | Result, upper bits passed through for narrow sizes |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| carry_o | output | 1 | Carry flag |
| xflag_o | output | 1 | New extend flag |
| valid_o | output | 1 | Result and flags are new this cycle |

## Verification
The bench targets counts equal to and above the operand width. A design that wraps the count modulo the width on a shift would return the operand instead of zero, or take carry from the wrong bit. It also drives rotates through extend with counts that are multiples of width+1, where a ring one bit short would show up as a rotated result. Zero counts are driven in every mode, so a design that leaves carry stale or clears it on an extend rotate is caught. Narrow operations carry nonzero upper operand bits, so a unit that zeroes or shifts into those bits shows it at once.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  parameter int DATA_W = 32;
  parameter int CNT_W  = 6;
  localparam int WB_W  = $clog2(DATA_W + 2);

  typedef enum logic [2:0] {
    OP_LSL = 3'd0, OP_LSR = 3'd1, OP_ASL = 3'd2, OP_ASR = 3'd3,
    OP_ROL = 3'd4, OP_ROR = 3'd5, OP_RXL = 3'd6, OP_RXR = 3'd7
  } shr_op_e;

  function automatic logic [WB_W-1:0] size_bits(logic [1:0] s);
    case (s)
      2'd0:    return WB_W'(8);
      2'd1:    return WB_W'(16);
      default: return WB_W'(DATA_W);
    endcase
  endfunction
endpackage

// File: rtl/shrot_shift.sv
module shrot_shift import shrot_pkg::*; (
  input  logic [2:0]        op_i,
  input  logic [WB_W-1:0]   w_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] res_o,
  output logic              last_o
);
  localparam int EXT_W = 3 * DATA_W;
  localparam int SGN_W = 2 * DATA_W;

  logic [CNT_W-1:0]        cm1;
  logic [EXT_W-1:0]        l_full, l_prev;
  logic [DATA_W-1:0]       r_prev;
  logic [SGN_W-1:0]        ext_mask;
  logic signed [SGN_W-1:0] sx, s_full, s_prev;

  always_comb begin
    cm1      = cnt_i - 1'b1;
    l_full   = EXT_W'(a_i) << cnt_i;
    l_prev   = (EXT_W'(a_i) << cm1) >> (w_i - 1'b1);
    r_prev   = a_i >> cm1;
    ext_mask = ~((SGN_W'(1) << w_i) - 1'b1);
    sx       = a_i[w_i - 1'b1] ? signed'(SGN_W'(a_i) | ext_mask) : signed'(SGN_W'(a_i));
    s_full   = sx >>> cnt_i;
    s_prev   = sx >>> cm1;
    case (op_i)
      OP_LSR:  begin res_o = a_i >> cnt_i;           last_o = r_prev[0]; end
      OP_ASR:  begin res_o = s_full[DATA_W-1:0];     last_o = s_prev[0]; end
      default: begin res_o = l_full[DATA_W-1:0];     last_o = l_prev[0]; end
    endcase
  end
endmodule

// File: rtl/shrot_rot.sv
module shrot_rot import shrot_pkg::*; #(
  parameter bit THRU_X = 1'b0
) (
  input  logic              left_i,
  input  logic [1:0]        size_i,
  input  logic [WB_W-1:0]   w_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              x_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              x_o
);
  localparam int RW = 2 * DATA_W;

  logic [WB_W-1:0] ring, c_mod, amt;
  logic [RW-1:0]   v, rot, rmask;

  // ring length: width, or width+1 with extend on top
  always_comb begin
    ring  = THRU_X ? w_i + 1'b1 : w_i;
    rmask = (RW'(1) << ring) - 1'b1;
    if (THRU_X) begin
      case (size_i)
        2'd0:    c_mod = WB_W'(32'(cnt_i) % 32'd9);
        2'd1:    c_mod = WB_W'(32'(cnt_i) % 32'd17);
        default: c_mod = WB_W'(32'(cnt_i) % 32'(DATA_W + 1));
      endcase
    end else begin
      c_mod = WB_W'(cnt_i) & (w_i - 1'b1);
    end
    amt = left_i ? c_mod : ((c_mod == '0) ? '0 : ring - c_mod);
    v   = RW'(a_i) | (THRU_X ? (RW'(x_i) << w_i) : '0);
    rot = ((v << amt) | (v >> (ring - amt))) & rmask;
  end

  generate
    if (THRU_X) begin : g_xring
      logic [RW-1:0] top_bit;
      always_comb begin
        top_bit = rot >> w_i;
        res_o   = rot[DATA_W-1:0] & DATA_W'(rmask >> 1);
        x_o     = top_bit[0];
        c_o     = top_bit[0];
      end
    end else begin : g_plain
      always_comb begin
        res_o = rot[DATA_W-1:0];
        x_o   = x_i;
        c_o   = left_i ? rot[0] : rot[w_i - 1'b1];
      end
    end
  endgenerate
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit import shrot_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              xflag_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              carry_o,
  output logic              xflag_o,
  output logic              valid_o
);
  logic [WB_W-1:0]   w;
  logic [DATA_W-1:0] mask, a, sh_res, rp_res, rx_res, res_n, merged;
  logic              sh_last, rp_c, rp_x, rx_c, rx_x, c_n, x_n, is_rx;
  logic [1:0]        size_q;

  always_comb begin
    w     = size_bits(size_i);
    mask  = DATA_W'(((2*DATA_W)'(1) << w) - 1'b1);
    a     = data_i & mask;
    is_rx = (op_i == OP_RXL) || (op_i == OP_RXR);
  end

  shrot_shift u_shift (
    .op_i(op_i), .w_i(w), .cnt_i(count_i), .a_i(a),
    .res_o(sh_res), .last_o(sh_last)
  );

  shrot_rot #(.THRU_X(1'b0)) u_rot_plain (
    .left_i(op_i == OP_ROL), .size_i(size_i), .w_i(w), .cnt_i(count_i),
    .a_i(a), .x_i(xflag_i), .res_o(rp_res), .c_o(rp_c), .x_o(rp_x)
  );

  shrot_rot #(.THRU_X(1'b1)) u_rot_ext (
    .left_i(op_i == OP_RXL), .size_i(size_i), .w_i(w), .cnt_i(count_i),
    .a_i(a), .x_i(xflag_i), .res_o(rx_res), .c_o(rx_c), .x_o(rx_x)
  );

  always_comb begin
    case (op_i)
      OP_ROL, OP_ROR: begin res_n = rp_res; c_n = rp_c;    x_n = rp_x;    end
      OP_RXL, OP_RXR: begin res_n = rx_res; c_n = rx_c;    x_n = rx_x;    end
      default:        begin res_n = sh_res; c_n = sh_last; x_n = sh_last; end
    endcase
    if (count_i == '0) begin
      res_n = a;
      x_n   = xflag_i;
      c_n   = is_rx ? xflag_i : 1'b0;
    end
    res_n  = res_n & mask;
    merged = (data_i & ~mask) | res_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      zero_o   <= 1'b0;
      neg_o    <= 1'b0;
      carry_o  <= 1'b0;
      xflag_o  <= 1'b0;
      valid_o  <= 1'b0;
      size_q   <= 2'd0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= merged;
        zero_o   <= (res_n == '0);
        neg_o    <= res_n[w - 1'b1];
        carry_o  <= c_n;
        xflag_o  <= x_n;
        size_q   <= size_i;
      end
    end
  end

  assert_zero_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && count_i == '0 && !is_rx |=>
      !carry_o && result_o == $past(data_i) && xflag_o == $past(xflag_i));

  assert_plain_rot_keeps_x_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_ROL || op_i == OP_ROR) |=> xflag_o == $past(xflag_i));

  assert_shift_c_eq_x_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !op_i[2] && count_i != '0 |=> carry_o == xflag_o);

  assert_rx_c_eq_x_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_rx |=> carry_o == xflag_o);

  assert_lsr_zero_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_LSR && count_i != '0 |=> !neg_o);

  assert_neg_msb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> neg_o == result_o[size_bits(size_q) - 1'b1]);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(carry_o) && $stable(xflag_o) && !valid_o);
endmodule

// File: tb/shrot_unit_test.sv
module shrot_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, xflag_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [5:0]  count_i = '0;
  logic [31:0] data_i = '0, result_o;
  logic        zero_o, neg_o, carry_o, xflag_o, valid_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shrot_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
    .count_i(count_i), .data_i(data_i), .xflag_i(xflag_i), .result_o(result_o),
    .zero_o(zero_o), .neg_o(neg_o), .carry_o(carry_o), .xflag_o(xflag_o), .valid_o(valid_o)
  );

  // bit-serial reference: {x, c, z, n, result}
  function automatic logic [35:0] ref_model(int op, int sz, int cnt, logic [31:0] d, logic x);
    int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    logic [31:0] m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    logic [31:0] a = d & m, r;
    logic c = 1'b0, o, s;
    if (cnt == 0) c = (op >= 6) ? x : 1'b0;
    for (int i = 0; i < cnt; i++) begin
      case (op)
        0, 2: begin o = a[w-1]; a = (a << 1) & m; x = o; end
        1:    begin o = a[0]; a = a >> 1; x = o; end
        3:    begin o = a[0]; s = a[w-1]; a = (a >> 1) | (32'(s) << (w-1)); x = o; end
        4:    begin o = a[w-1]; a = ((a << 1) | 32'(o)) & m; end
        5:    begin o = a[0]; a = (a >> 1) | (32'(o) << (w-1)); end
        6:    begin o = a[w-1]; a = ((a << 1) | 32'(x)) & m; x = o; end
        default: begin o = a[0]; a = (a >> 1) | (32'(x) << (w-1)); x = o; end
      endcase
      c = o;
    end
    r = (d & ~m) | a;
    return {x, c, (a == 0), a[w-1], r};
  endfunction

  function automatic string op_tag(int op, int cnt);
    if (cnt == 0) return "R7";
    case (op)
      0, 2: return "R2";
      1:    return "R3";
      3:    return "R4";
      4, 5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(int op, int sz, int cnt, logic [31:0] d, logic x);
    logic [35:0] e = ref_model(op, sz, cnt, d, x);
    string t = op_tag(op, cnt);
    @(negedge clk);
    op_i = 3'(op); size_i = 2'(sz); count_i = 6'(cnt); data_i = d; xflag_i = x; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk(t, "result", result_o, e[31:0]);
    chk(t, "carry", 32'(carry_o), 32'(e[34]));
    chk(t, "extend", 32'(xflag_o), 32'(e[35]));
    chk("R8", "zero", 32'(zero_o), 32'(e[33]));
    chk("R8", "neg", 32'(neg_o), 32'(e[32]));
    chk("R9", "valid", 32'(valid_o), 32'd1);
  endtask

  initial begin
    logic [31:0] held;
    int unused_seed;
    unused_seed = $urandom(32'h5A17);
    #(3*CLK_PERIOD);
    chk("R9", "reset result", result_o, 32'd0);
    chk("R9", "reset valid", 32'(valid_o), 32'd0);
    chk("R9", "reset flags", 32'({zero_o, neg_o, carry_o, xflag_o}), 32'd0);
    @(negedge clk); rst_ni = 1'b1;

    // R7: zero count in every mode and size
    for (int op = 0; op < 8; op++)
      for (int sz = 0; sz < 3; sz++) run(op, sz, 0, 32'hC3A5_F081, op[0]);
    // R1: upper bits pass through on narrow sizes
    run(0, 0, 3, 32'hDEAD_BE81, 1'b0);
    chk("R1", "upper byte kept", result_o & 32'hFFFF_FF00, 32'hDEAD_BE00);
    run(1, 1, 4, 32'hCAFE_8001, 1'b1);
    chk("R1", "upper word kept", result_o & 32'hFFFF_0000, 32'hCAFE_0000);
    run(3, 3, 1, 32'h8000_0001, 1'b0);
    // R2: count at and above width
    run(0, 0, 8, 32'h0000_0001, 1'b0);
    run(2, 0, 9, 32'h0000_00FF, 1'b1);
    run(0, 2, 32, 32'h0000_0001, 1'b0);
    run(0, 2, 63, 32'hFFFF_FFFF, 1'b1);
    // R3 / R4
    run(1, 0, 8, 32'h0000_0080, 1'b0);
    run(1, 2, 31, 32'h8000_0000, 1'b0);
    run(3, 0, 20, 32'h0000_0080, 1'b0);
    run(3, 1, 5, 32'h0000_8010, 1'b0);
    run(3, 2, 63, 32'h7FFF_FFFF, 1'b1);
    // R5: rotates by full width and beyond
    run(4, 0, 8, 32'h0000_0081, 1'b0);
    run(5, 1, 17, 32'h0000_0001, 1'b1);
    run(4, 2, 33, 32'h8000_0000, 1'b0);
    // R6: ring of width+1
    run(6, 0, 9, 32'h0000_005A, 1'b1);
    run(7, 0, 1, 32'h0000_0001, 1'b1);
    run(6, 1, 16, 32'h0000_0001, 1'b0);
    run(7, 2, 33, 32'h1234_5678, 1'b1);
    run(6, 2, 32, 32'h8000_0000, 1'b0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom_range(0, 7));
      int sz = int'($urandom_range(0, 3));
      int cnt = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 63));
      run(op, sz, cnt, $urandom, 1'($urandom));
    end

    // R9: outputs hold with valid low
    run(4, 2, 5, 32'h0F0F_1234, 1'b1);
    held = result_o;
    @(negedge clk); data_i = 32'hFFFF_FFFF; count_i = 6'd7; op_i = 3'd1;
    @(negedge clk);
    chk("R9", "hold result", result_o, held);
    chk("R9", "hold valid", 32'(valid_o), 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000*CLK_PERIOD);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule